// File: doc/BRIEF.md
# Mailbox Command Requester

This block is the host-side engine that hands one command to a co-processor and collects its answer. A command is a five-word message placed in a shared message area: type, opcode, argument count, one argument, and an additive check word. When `start` is pulsed with a command index, the engine writes the message for that index, rings a doorbell register, and polls a reply register at a fixed cycle spacing. Polling stops when the reply register is non-zero or when a poll budget runs out.

After a reply arrives, the engine reads the five reply words back and clears the reply register. It then resolves one status word. A timeout takes precedence over everything else. Next comes a bad check word in the reply. Otherwise the status is the code the co-processor placed in the reply register. The status and the returned argument word come out together with a one-cycle `done` pulse.

All register and message accesses go through one simple bus port. The port carries one access at a time. Read data is valid in the cycle after the read request and stays stable until the next read.

Top module: `mbox_cmd_requester`

## Requirements
- R1: During and directly after reset, `busy`, `done` and `bus_req` are low.
- R2: On an accepted `start`, the five message words are written in field order to byte addresses 0x100, 0x104, 0x108, 0x10C and 0x110. The words for index 0 are {1,1,1,1,4}, for index 1 {1,2,1,1,5}, and for index 2 {1,2,1,2,6}.
- R3: Right after the last message word, exactly one write of value 1 goes to the doorbell at address 0x10.
- R4: The reply register at address 0x14 is read repeatedly, one read every `POLL_PERIOD` cycles. The response is accepted if it appears on any read up to and including read number `POLL_MAX`.
- R5: If `POLL_MAX` reads of 0x14 all return zero, the status is 0x8000_0010 (timeout), no reply words are read, and the argument output is zero.
- R6: After a non-zero reply, the five reply words are read in field order from 0x100 through 0x110.
- R7: Every command that reached the bus ends with a write of 0 to 0x14. That write is the last bus access before `done`.
- R8: If the fifth reply word is not the 32-bit sum of the first four, the status is 0x8000_0004, whatever code the reply register held.
- R9: With a valid check word, the status equals the reply-register value. 0x1 means success. Error codes set bit 31 plus one bit: bit 0 header, bit 1 invalid command, bit 2 check word, bit 3 malformed. The argument output equals the fourth reply word.
- R10: A `start` while `busy` is high is ignored: no extra bus access and no extra `done`.
- R11: A `start` with index 3 makes no bus access and gives `done` on the next cycle with status 0x8000_0002.
- R12: `done` is high for exactly one cycle per command, and `busy` is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse to issue a command |
| cmd_idx | input | 2 | Command index, 0 to 2 valid |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 32 | Resolved status code, valid from `done` |
| arg0_out | output | 32 | Returned argument word, valid from `done` |
| bus_req | output | 1 | Bus access request this cycle |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | ADDR_W (12) | Byte address |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid the cycle after a read |

## Verification
Two decisions can land on the same poll read: the read that uses up the last of the poll budget can also be the one that returns a non-zero reply. The co-processor model is told to answer on exactly read `POLL_MAX`, where the reply must win and the full reply read-back must follow. It is also told to answer one read later, where the result must be a timeout with no reply reads. Each case is judged on the status word, the number of reply-register reads, the number of message reads, and the total count of bus accesses.

// File: rtl/mbox_req_pkg.sv
package mbox_req_pkg;

    localparam int WORD_W    = 32;
    localparam int MSG_WORDS = 5;
    localparam int CMD_COUNT = 3;
    localparam int IDX_W     = $clog2(CMD_COUNT + 1);

    // field positions inside a message
    localparam int FLD_ARG0 = 3;
    localparam int FLD_SUM  = MSG_WORDS - 1;

    // byte offsets on the bus
    localparam int MSG_BASE     = 'h100;
    localparam int DOORBELL_OFS = 'h10;
    localparam int REPLY_OFS    = 'h14;

    // status encoding
    localparam int ERR_FLAG_BIT = 31;
    localparam logic [WORD_W-1:0] ST_OK      = 32'h1;
    localparam logic [WORD_W-1:0] ST_BADCMD  = (32'h1 << ERR_FLAG_BIT) | (32'h1 << 1);
    localparam logic [WORD_W-1:0] ST_SUMERR  = (32'h1 << ERR_FLAG_BIT) | (32'h1 << 2);
    localparam logic [WORD_W-1:0] ST_TIMEOUT = (32'h1 << ERR_FLAG_BIT) | (32'h1 << 4);

    typedef enum logic [3:0] {
        S_IDLE,
        S_WRITE,
        S_RING,
        S_POLL_RD,
        S_POLL_CHK,
        S_POLL_WAIT,
        S_RSP_RD,
        S_RSP_CAP,
        S_CLEAR
    } req_state_e;

    typedef struct packed {
        logic [WORD_W-1:0] code;
        logic [WORD_W-1:0] arg0;
    } req_result_t;

    // message word for a command index and a field number
    function automatic logic [WORD_W-1:0] cmd_field(input int unsigned idx,
                                                    input int unsigned fld);
        logic [WORD_W-1:0] kind, op, argc, arg;
        kind = 32'd1;
        op   = (idx == 0) ? 32'd1 : 32'd2;
        argc = 32'd1;
        arg  = (idx == 2) ? 32'd2 : 32'd1;
        case (fld)
            0:       return kind;
            1:       return op;
            2:       return argc;
            3:       return arg;
            default: return kind + op + argc + arg;
        endcase
    endfunction

    // status precedence: timeout, then bad check word, then reply code
    function automatic logic [WORD_W-1:0] resolve_status(input logic timed_out,
                                                         input logic sum_ok,
                                                         input logic [WORD_W-1:0] code);
        if (timed_out)
            return ST_TIMEOUT;
        else if (!sum_ok)
            return ST_SUMERR;
        else
            return code;
    endfunction

endpackage

// File: rtl/mbox_sum_acc.sv
module mbox_sum_acc #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         add_en,
    input  logic [W-1:0] add_val,
    output logic [W-1:0] sum
);
    always_ff @(posedge clk) begin
        if (rst || clr)
            sum <= '0;
        else if (add_en)
            sum <= sum + add_val;
    end
endmodule

// File: rtl/mbox_poll_timer.sv
module mbox_poll_timer #(
    parameter int POLL_MAX    = 200000,
    parameter int POLL_PERIOD = 1250
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic gap_clr,
    input  logic gap_tick,
    input  logic poll_step,
    output logic gap_done,
    output logic last_poll
);
    localparam int GAP_LAST = POLL_PERIOD - 3;
    localparam int GAP_W    = $clog2(POLL_PERIOD);
    localparam int CNT_W    = $clog2(POLL_MAX + 1);

    logic [GAP_W-1:0] gap_cnt;
    logic [CNT_W-1:0] poll_cnt;

    always_ff @(posedge clk) begin
        if (rst || gap_clr)
            gap_cnt <= '0;
        else if (gap_tick)
            gap_cnt <= gap_cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || arm)
            poll_cnt <= '0;
        else if (poll_step)
            poll_cnt <= poll_cnt + 1'b1;
    end

    assign gap_done  = (gap_cnt == GAP_W'(GAP_LAST));
    assign last_poll = (poll_cnt == CNT_W'(POLL_MAX - 1));
endmodule

// File: rtl/mbox_cmd_requester.sv
module mbox_cmd_requester
    import mbox_req_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int POLL_MAX    = 200000,
    parameter int POLL_PERIOD = 1250
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [IDX_W-1:0]  cmd_idx,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] status,
    output logic [WORD_W-1:0] arg0_out,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [WORD_W-1:0] bus_wdata,
    input  logic [WORD_W-1:0] bus_rdata
);
    localparam int FLD_W = $clog2(MSG_WORDS);
    localparam logic [FLD_W-1:0] FLD_LAST = FLD_W'(MSG_WORDS - 1);

    req_state_e        state;
    logic [FLD_W-1:0]  fld;
    logic [IDX_W-1:0]  idx_q;
    logic [WORD_W-1:0] reply_code;
    logic              timed_out;
    logic              sum_ok_q;
    logic              done_q;
    req_result_t       res_q;

    logic              accept;
    logic              reply_seen;
    logic              gap_done;
    logic              last_poll;
    logic              acc_add;
    logic [WORD_W-1:0] acc_sum;

    assign accept     = (state == S_IDLE) && start;
    assign reply_seen = (bus_rdata != '0);
    assign acc_add    = (state == S_RSP_CAP) && (fld != FLD_LAST);

    mbox_poll_timer #(
        .POLL_MAX    (POLL_MAX),
        .POLL_PERIOD (POLL_PERIOD)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .arm       (accept),
        .gap_clr   (state == S_POLL_CHK),
        .gap_tick  (state == S_POLL_WAIT),
        .poll_step ((state == S_POLL_CHK) && !reply_seen),
        .gap_done  (gap_done),
        .last_poll (last_poll)
    );

    mbox_sum_acc #(
        .W (WORD_W)
    ) u_sum (
        .clk     (clk),
        .rst     (rst),
        .clr     (accept),
        .add_en  (acc_add),
        .add_val (bus_rdata),
        .sum     (acc_sum)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= S_IDLE;
            fld        <= '0;
            idx_q      <= '0;
            reply_code <= '0;
            timed_out  <= 1'b0;
            sum_ok_q   <= 1'b0;
            done_q     <= 1'b0;
            res_q      <= '0;
        end else begin
            done_q <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (start) begin
                        if (int'(cmd_idx) >= CMD_COUNT) begin
                            done_q     <= 1'b1;
                            res_q.code <= ST_BADCMD;
                            res_q.arg0 <= '0;
                        end else begin
                            idx_q      <= cmd_idx;
                            fld        <= '0;
                            timed_out  <= 1'b0;
                            sum_ok_q   <= 1'b0;
                            res_q.arg0 <= '0;
                            state      <= S_WRITE;
                        end
                    end
                end
                S_WRITE: begin
                    if (fld == FLD_LAST) begin
                        fld   <= '0;
                        state <= S_RING;
                    end else begin
                        fld <= fld + 1'b1;
                    end
                end
                S_RING:    state <= S_POLL_RD;
                S_POLL_RD: state <= S_POLL_CHK;
                S_POLL_CHK: begin
                    if (reply_seen) begin
                        reply_code <= bus_rdata;
                        fld        <= '0;
                        state      <= S_RSP_RD;
                    end else if (last_poll) begin
                        timed_out <= 1'b1;
                        state     <= S_CLEAR;
                    end else begin
                        state <= S_POLL_WAIT;
                    end
                end
                S_POLL_WAIT: begin
                    if (gap_done)
                        state <= S_POLL_RD;
                end
                S_RSP_RD: state <= S_RSP_CAP;
                S_RSP_CAP: begin
                    if (fld == FLD_W'(FLD_ARG0))
                        res_q.arg0 <= bus_rdata;
                    if (fld == FLD_LAST) begin
                        sum_ok_q <= (acc_sum == bus_rdata);
                        state    <= S_CLEAR;
                    end else begin
                        fld   <= fld + 1'b1;
                        state <= S_RSP_RD;
                    end
                end
                S_CLEAR: begin
                    done_q     <= 1'b1;
                    res_q.code <= resolve_status(timed_out, sum_ok_q, reply_code);
                    state      <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // bus drive decoded from the sequencer state
    always_comb begin
        bus_req   = 1'b0;
        bus_we    = 1'b0;
        bus_addr  = '0;
        bus_wdata = '0;
        case (state)
            S_WRITE: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                bus_addr  = ADDR_W'(MSG_BASE + 4 * int'(fld));
                bus_wdata = cmd_field(32'(idx_q), 32'(fld));
            end
            S_RING: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                bus_addr  = ADDR_W'(DOORBELL_OFS);
                bus_wdata = 32'd1;
            end
            S_POLL_RD: begin
                bus_req  = 1'b1;
                bus_addr = ADDR_W'(REPLY_OFS);
            end
            S_RSP_RD: begin
                bus_req  = 1'b1;
                bus_addr = ADDR_W'(MSG_BASE + 4 * int'(fld));
            end
            S_CLEAR: begin
                bus_req  = 1'b1;
                bus_we   = 1'b1;
                bus_addr = ADDR_W'(REPLY_OFS);
            end
            default: ;
        endcase
    end

    assign busy     = (state != S_IDLE);
    assign done     = done_q;
    assign status   = res_q.code;
    assign arg0_out = res_q.arg0;
endmodule

// File: rtl/mbox_req_checker.sv
module mbox_req_checker
    import mbox_req_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              done,
    input logic [WORD_W-1:0] status,
    input logic [WORD_W-1:0] arg0_out,
    input logic              bus_req,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [WORD_W-1:0] bus_wdata
);
    // R12: completion pulse lasts one cycle
    a_r12_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R12: the sequencer is idle when it reports completion
    a_r12_idle_at_done: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R10: no bus traffic outside a command
    a_r10_quiet_when_idle: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !bus_req);

    // R3: doorbell is always written with 1
    a_r3_doorbell_one: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_we && bus_addr == ADDR_W'(DOORBELL_OFS)) |-> bus_wdata == 32'd1);

    // R7: a command that used the bus ends with the reply register cleared
    a_r7_clear_last: assert property (@(posedge clk) disable iff (rst)
        (done && $past(busy)) |->
        $past(bus_req && bus_we && bus_addr == ADDR_W'(REPLY_OFS) && bus_wdata == '0));

    // R5: timeout returns a zero argument
    a_r5_timeout_zero_arg: assert property (@(posedge clk) disable iff (rst)
        (done && status == ST_TIMEOUT) |-> arg0_out == '0);

    // R11: an unknown index completes without ever leaving idle
    a_r11_badcmd_no_busy: assert property (@(posedge clk) disable iff (rst)
        (done && status == ST_BADCMD) |-> !$past(busy));
endmodule

bind mbox_cmd_requester mbox_req_checker #(.ADDR_W(ADDR_W)) u_req_checker (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .done      (done),
    .status    (status),
    .arg0_out  (arg0_out),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata)
);

// File: tb/test_mbox_cmd_requester.sv
`timescale 1ns/1ps
module test_mbox_cmd_requester;
    import mbox_req_pkg::*;

    localparam int AW = 12;
    localparam int PM = 6;
    localparam int PP = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [1:0]  cmd_idx = 2'd0;
    logic        busy, done, bus_req, bus_we;
    logic [31:0] status, arg0_out, bus_wdata;
    logic [AW-1:0] bus_addr;
    logic [31:0] bus_rdata = '0;

    always #2 clk = ~clk;

    mbox_cmd_requester #(.ADDR_W(AW), .POLL_MAX(PM), .POLL_PERIOD(PP)) i_mbox_cmd_requester (
        .clk(clk), .rst(rst), .start(start), .cmd_idx(cmd_idx), .busy(busy), .done(done),
        .status(status), .arg0_out(arg0_out), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

    int n_cmp = 0;
    int n_bad = 0;
    longint cyc = 0;
    always @(posedge clk) cyc++;

    task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] expv);
        n_cmp++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, expv);
        end
    endtask

    // ---------------- co-processor and memory model ----------------
    int          resp_after;
    logic [31:0] m_code, m_arg;
    bit          m_corrupt;
    logic [31:0] mem [0:127];
    logic [31:0] wr_log [0:4];
    logic [31:0] msg_snap [0:4];
    int bus_cnt = 0, ring_cnt = 0, gap_bad = 0, order_bad = 0;
    int poll_reads = 0, rsp_reads = 0;
    longint last_poll_cyc = 0;
    bit last_was_clear = 0;

    always @(negedge clk) begin
        if (!rst && bus_req) begin
            int w;
            w = int'(bus_addr) >> 2;
            bus_cnt++;
            last_was_clear = bus_we && int'(bus_addr) == 'h14 && bus_wdata == 0;
            if (bus_we) begin
                if (int'(bus_addr) >= 'h100 && int'(bus_addr) < 'h114)
                    wr_log[(int'(bus_addr) - 'h100) / 4] = bus_wdata;
                mem[w] = bus_wdata;
                if (int'(bus_addr) == 'h10) begin
                    ring_cnt++;
                    for (int i = 0; i < 5; i++) msg_snap[i] = wr_log[i];
                    for (int i = 0; i < 5; i++) wr_log[i] = '0;
                    poll_reads = 0;
                    rsp_reads  = 0;
                    mem[64] = 32'd2;
                    mem[65] = 32'd2;
                    mem[66] = 32'd1;
                    mem[67] = m_arg;
                    mem[68] = 32'd5 + m_arg + (m_corrupt ? 32'd1 : 32'd0);
                end
            end else if (int'(bus_addr) == 'h14) begin
                if (poll_reads > 0 && (cyc - last_poll_cyc) != PP) gap_bad++;
                last_poll_cyc = cyc;
                bus_rdata = (resp_after >= 0 && poll_reads >= resp_after) ? m_code : 32'd0;
                poll_reads++;
            end else begin
                if (int'(bus_addr) != 'h100 + 4 * rsp_reads) order_bad++;
                bus_rdata = mem[w];
                rsp_reads++;
            end
        end
    end

    // ---------------- scoreboard ----------------
    typedef struct packed {
        logic [31:0]      st;
        logic [31:0]      a0;
        int               polls;
        int               rsp;
        logic [4:0][31:0] msg;
        logic             has_msg;
        int               bus_delta;
        int               base_bus;
        int               base_ring;
        int               base_gap;
        int               base_order;
    } exp_t;

    exp_t q[$];
    int done_cnt = 0;
    bit prev_done = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (done && prev_done) chk("R12", "done width", 32'd2, 32'd1);
            prev_done = done;
            if (done) begin
                done_cnt++;
                chk("R12", "busy at done", 32'(busy), 32'd0);
                if (q.size() == 0) begin
                    chk("R10", "unexpected done", 32'd1, 32'd0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk("R5/R8/R9/R11", "status", status, e.st);
                    chk("R5/R9", "arg0", arg0_out, e.a0);
                    chk("R10/R11", "bus accesses", 32'(bus_cnt - e.base_bus), 32'(e.bus_delta));
                    if (e.has_msg) begin
                        for (int i = 0; i < 5; i++)
                            chk("R2", $sformatf("message word %0d", i), msg_snap[i], e.msg[i]);
                        chk("R3", "doorbell writes", 32'(ring_cnt - e.base_ring), 32'd1);
                        chk("R4/R5", "reply polls", 32'(poll_reads), 32'(e.polls));
                        chk("R4", "poll spacing errors", 32'(gap_bad - e.base_gap), 32'd0);
                        chk("R6", "reply word reads", 32'(rsp_reads), 32'(e.rsp));
                        chk("R6", "reply read order errors", 32'(order_bad - e.base_order), 32'd0);
                        chk("R7", "clear is last access", 32'(last_was_clear), 32'd1);
                    end
                end
            end
        end
    end

    // ---------------- driver ----------------
    task automatic run(input int idx, input int ra, input logic [31:0] code,
                       input logic [31:0] arg, input bit corrupt, input bit poke);
        exp_t e;
        bit tmo;
        int target;
        tmo = (ra < 0) || (ra >= PM);
        e = '0;
        e.has_msg = (idx < 3);
        e.msg[0] = 32'd1;
        e.msg[1] = (idx == 0) ? 32'd1 : 32'd2;
        e.msg[2] = 32'd1;
        e.msg[3] = (idx == 2) ? 32'd2 : 32'd1;
        e.msg[4] = (idx == 0) ? 32'd4 : (idx == 1) ? 32'd5 : 32'd6;
        if (idx >= 3) begin
            e.st = 32'h8000_0002; e.a0 = 0; e.bus_delta = 0;
        end else begin
            e.polls = tmo ? PM : ra + 1;
            e.rsp   = tmo ? 0 : 5;
            e.st    = tmo ? 32'h8000_0010 : corrupt ? 32'h8000_0004 : code;
            e.a0    = tmo ? 32'd0 : arg;
            e.bus_delta = 5 + 1 + e.polls + e.rsp + 1;
        end
        e.base_bus = bus_cnt; e.base_ring = ring_cnt;
        e.base_gap = gap_bad; e.base_order = order_bad;
        resp_after = ra; m_code = code; m_arg = arg; m_corrupt = corrupt;
        q.push_back(e);
        target = done_cnt + 1;
        @(negedge clk); start = 1'b1; cmd_idx = 2'(idx);
        @(negedge clk); start = 1'b0;
        if (poke) begin
            repeat (2) @(negedge clk);
            start = 1'b1; cmd_idx = 2'd3;
            @(negedge clk); start = 1'b0;
        end
        while (done_cnt < target) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                chk("R1", "busy in reset", 32'(busy), 32'd0);
                chk("R1", "bus_req in reset", 32'(bus_req), 32'd0);
                rst = 1'b0;
                @(negedge clk);
                chk("R1", "busy after reset", 32'(busy), 32'd0);
                chk("R1", "done after reset", 32'(done), 32'd0);
                chk("R1", "bus_req after reset", 32'(bus_req), 32'd0);
                run(0, 0, 32'h1, 32'hA1B2_C3D4, 0, 0);          // R9 immediate reply
                run(1, 2, 32'h1, 32'h0000_5A5A, 0, 0);          // R4 several polls
                run(2, PM - 1, 32'h1, 32'h1234_0002, 0, 0);     // R4 reply on last poll
                run(0, -1, 32'h1, 32'h0, 0, 0);                 // R5 never replies
                run(2, PM, 32'h1, 32'h0BAD_0BAD, 0, 0);         // R5 reply one poll late
                run(1, 1, 32'h8000_0008, 32'hDEAD_0001, 0, 0);  // R9 error code passes
                run(2, 0, 32'h1, 32'h0000_0077, 1, 0);          // R8 bad check word
                run(0, 3, 32'h8000_0001, 32'h0000_0088, 1, 0);  // R8 overrides reply code
                run(3, 0, 32'h1, 32'h0, 0, 0);                  // R11 unknown index
                run(1, 3, 32'h1, 32'h0000_CAFE, 0, 1);          // R10 start while busy
                repeat (10) @(negedge clk);
                chk("R10", "pending results", 32'(q.size()), 32'd0);
            end
            begin
                repeat (20000) @(posedge clk);
                n_cmp++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule